// File: doc/BRIEF.md
# Hint-and-Idle Gated Clock Controller

This block produces gated clocks for a set of transactional units (five by default). Each unit clock comes from a shared root clock. Software writes a hint register in the register clock domain. Each hint bit asks for one unit clock to run or to stop. A cleared hint is only a request to stop. The clock stops only when the unit also reports idle. A unit that is busy keeps its clock running.

The root enable from the power manager can stop every unit clock. A 4-bit scan-mode input acts asynchronously and overrides all other controls, forcing every clock on. Idle and scan-mode inputs use a 4-bit redundant encoding in which true is `4'h6` and false is `4'h9`. Only the exact true code counts as asserted. Any other value is treated as not asserted.

Hint bits are synchronized into the root clock domain before they reach the gating logic. A status vector brings the actual gating state back into the register clock domain.

Top module: `hgc_ctrl`

## Requirements
- R1: After reset, every bit of `hint_q_o` reads 1, and with the root enable on every unit clock runs.
- R2: A write (`hint_we_i` high at a `clk_i` edge) loads `hint_wdata_i` into the hint register, which `hint_q_o` shows from the next cycle. Without a write, the register holds its value.
- R3: A unit whose hint bit (bit i) is 0 and whose idle field (`idle_i[4i+3:4i]`) equals `4'h6` has its clock stopped, within a few root clock cycles of the hint write.
- R4: A unit whose idle field equals `4'h9` (busy) keeps its clock running, even when its hint bit is 0.
- R5: Any idle field value other than `4'h6` (for example `4'h0`, `4'hF`, `4'h7`) is treated as busy, so the clock runs.
- R6: With `root_en_i` low and scan mode not true, every unit clock stops, whatever the hint and idle values.
- R7: With `scan_mode_i` equal to `4'h6`, every unit clock runs, even with `root_en_i` low. Any other scan code, such as `4'h9` or `4'h2`, has no effect.
- R8: Each unit's clock depends only on its own hint bit and its own idle field.
- R9: Bit i of `status_o` reads 1 when unit i's clock is enabled and 0 when it is stopped. The bit is synchronized into the `clk_i` domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_i | input | 1 | Synchronous active-high reset, used in both domains |
| hint_we_i | input | 1 | Hint register write strobe |
| hint_wdata_i | input | NUM_UNITS | Hint write data, one bit per unit |
| hint_q_o | output | NUM_UNITS | Hint register contents |
| status_o | output | NUM_UNITS | Per-unit clock-enabled status, in the clk_i domain |
| root_clk_i | input | 1 | Root clock for all units |
| root_en_i | input | 1 | Power-manager enable for the root clock |
| scan_mode_i | input | 4 | Scan-mode override, true = 4'h6 |
| idle_i | input | 4*NUM_UNITS | Per-unit idle fields, true = 4'h6 |
| gclk_o | output | NUM_UNITS | Gated unit clocks |

## Verification
The bench builds the block with its default parameters: five units and two synchronizer stages in each direction. With five units, a single hint write can mix units that stop, units held busy and units fed invalid idle codes. This brings independence between units and the strict idle decode into reach in one pass. Root and register clocks run at unrelated periods, so each check allows for the full synchronizer latency and counts gated clock edges over a window, not at a fixed edge.

// File: rtl/hgc_pkg.sv
package hgc_pkg;

    typedef logic [3:0] mb4_t;

    localparam mb4_t MB4_TRUE  = 4'h6;
    localparam mb4_t MB4_FALSE = 4'h9;

    // Only the exact true code counts as asserted.
    function automatic logic mb4_strict_true(mb4_t v);
        return (v == MB4_TRUE);
    endfunction

    // Per-unit controls presented to a gating cell.
    typedef struct packed {
        logic hint;     // software request to run
        logic idle;     // unit reports idle (strict decode)
        logic root_en;  // power-manager root enable (synchronized)
        logic scan;     // asynchronous scan override
    } gate_req_t;

    function automatic logic gate_enable(gate_req_t r);
        return ((r.hint | ~r.idle) & r.root_en) | r.scan;
    endfunction

endpackage

// File: rtl/hgc_sync.sv
module hgc_sync #(
    parameter int         WIDTH     = 1,
    parameter int         STAGES    = 2,
    parameter logic [0:0] RESET_VAL = 1'b0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[s] <= {WIDTH{RESET_VAL}};
                    else       stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) stage_q[s] <= {WIDTH{RESET_VAL}};
                    else       stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[LAST];
endmodule

// File: rtl/hgc_hint_reg.sv
module hgc_hint_reg #(
    parameter int NUM_UNITS = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 we_i,
    input  logic [NUM_UNITS-1:0] wdata_i,
    output logic [NUM_UNITS-1:0] q_o
);
    logic [NUM_UNITS-1:0] hint_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)     hint_q <= '1;
        else if (we_i) hint_q <= wdata_i;
    end

    assign q_o = hint_q;
endmodule

// File: rtl/hgc_unit_gate.sv
module hgc_unit_gate
    import hgc_pkg::*;
(
    input  logic      root_clk_i,
    input  gate_req_t req_i,
    output logic      en_o,
    output logic      gclk_o
);
    logic en_d;
    logic en_l;

    assign en_d = gate_enable(req_i);

    // Transparent while the root clock is low, so the enable only changes
    // while the gated output is held low.
    always_latch begin
        if (!root_clk_i) en_l = en_d;
    end

    assign en_o   = en_l;
    assign gclk_o = root_clk_i & en_l;
endmodule

// File: rtl/hgc_ctrl.sv
module hgc_ctrl
    import hgc_pkg::*;
#(
    parameter int NUM_UNITS   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   hint_we_i,
    input  logic [NUM_UNITS-1:0]   hint_wdata_i,
    output logic [NUM_UNITS-1:0]   hint_q_o,
    output logic [NUM_UNITS-1:0]   status_o,
    input  logic                   root_clk_i,
    input  logic                   root_en_i,
    input  logic [3:0]             scan_mode_i,
    input  logic [4*NUM_UNITS-1:0] idle_i,
    output logic [NUM_UNITS-1:0]   gclk_o
);
    localparam int IDLE_W = 4 * NUM_UNITS;

    logic [NUM_UNITS-1:0] hint_q;
    logic [NUM_UNITS-1:0] hint_s;
    logic                 root_en_s;
    logic                 scan_t;
    logic [NUM_UNITS-1:0] idle_t;
    logic [NUM_UNITS-1:0] gate_en;

    hgc_hint_reg #(.NUM_UNITS(NUM_UNITS)) u_hint (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .we_i    (hint_we_i),
        .wdata_i (hint_wdata_i),
        .q_o     (hint_q)
    );

    // Register domain -> root domain
    hgc_sync #(.WIDTH(NUM_UNITS), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_hint_sync (
        .clk_i (root_clk_i),
        .rst_i (rst_i),
        .d_i   (hint_q),
        .q_o   (hint_s)
    );

    hgc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_root_en_sync (
        .clk_i (root_clk_i),
        .rst_i (rst_i),
        .d_i   (root_en_i),
        .q_o   (root_en_s)
    );

    // Scan override is used without synchronization.
    assign scan_t = mb4_strict_true(scan_mode_i);

    generate
        for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
            gate_req_t req;

            assign idle_t[u]   = mb4_strict_true(idle_i[4*u +: 4]);
            assign req.hint    = hint_s[u];
            assign req.idle    = idle_t[u];
            assign req.root_en = root_en_s;
            assign req.scan    = scan_t;

            hgc_unit_gate u_gate (
                .root_clk_i (root_clk_i),
                .req_i      (req),
                .en_o       (gate_en[u]),
                .gclk_o     (gclk_o[u])
            );
        end
    endgenerate

    // Root domain -> register domain
    hgc_sync #(.WIDTH(NUM_UNITS), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_status_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (gate_en),
        .q_o   (status_o)
    );

    assign hint_q_o = hint_q;

    logic unused_idle_w;
    assign unused_idle_w = (IDLE_W == 0);
endmodule

// File: rtl/hgc_ctrl_chk.sv
module hgc_ctrl_chk
    import hgc_pkg::*;
#(
    parameter int NUM_UNITS = 5
) (
    input logic                   clk_i,
    input logic                   root_clk_i,
    input logic                   rst_i,
    input logic                   hint_we_i,
    input logic [NUM_UNITS-1:0]   hint_wdata_i,
    input logic [NUM_UNITS-1:0]   hint_q_o,
    input logic [3:0]             scan_mode_i,
    input logic [4*NUM_UNITS-1:0] idle_i,
    input logic [NUM_UNITS-1:0]   hint_s,
    input logic                   root_en_s,
    input logic [NUM_UNITS-1:0]   gate_en
);
    logic [NUM_UNITS-1:0] idle_exact;
    logic                 scan_on;

    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++)
            idle_exact[u] = (idle_i[4*u +: 4] == MB4_TRUE);
    end
    assign scan_on = (scan_mode_i == MB4_TRUE);

    // R1
    a_r1_hint_reset_ones: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (hint_q_o == '1));

    // R2
    a_r2_write_loads: assert property (@(posedge clk_i) disable iff (rst_i)
        hint_we_i |=> (hint_q_o == $past(hint_wdata_i)));

    // R2
    a_r2_hold_without_write: assert property (@(posedge clk_i) disable iff (rst_i)
        !hint_we_i |=> $stable(hint_q_o));

    // R3
    a_r3_idle_unhinted_stops: assert property (@(posedge root_clk_i) disable iff (rst_i)
        !scan_on |-> ((gate_en & ~hint_s & idle_exact) == '0));

    // R4, R5
    a_r4_busy_keeps_running: assert property (@(posedge root_clk_i) disable iff (rst_i)
        root_en_s |-> ((~gate_en & ~idle_exact) == '0));

    // R6
    a_r6_root_off_stops_all: assert property (@(posedge root_clk_i) disable iff (rst_i)
        (!root_en_s && !scan_on) |-> (gate_en == '0));

    // R7
    a_r7_scan_forces_on: assert property (@(posedge root_clk_i) disable iff (rst_i)
        (scan_on && $past(scan_on)) |-> (gate_en == '1));
endmodule

bind hgc_ctrl hgc_ctrl_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk_i        (clk_i),
    .root_clk_i   (root_clk_i),
    .rst_i        (rst_i),
    .hint_we_i    (hint_we_i),
    .hint_wdata_i (hint_wdata_i),
    .hint_q_o     (hint_q_o),
    .scan_mode_i  (scan_mode_i),
    .idle_i       (idle_i),
    .hint_s       (hint_s),
    .root_en_s    (root_en_s),
    .gate_en      (gate_en)
);

// File: tb/hgc_ctrl_tb.sv
`timescale 1ns/100ps
module hgc_ctrl_tb;
    localparam int N = 5;
    localparam int WIN = 20;       // clk_i cycles per measurement window
    localparam int RUN_MIN = 14;   // root edges expected in a window when running

    logic           clk_i = 1'b0;
    logic           root_clk_i = 1'b0;
    logic           rst_i = 1'b1;
    logic           hint_we_i = 1'b0;
    logic [N-1:0]   hint_wdata_i = '0;
    logic [N-1:0]   hint_q_o;
    logic [N-1:0]   status_o;
    logic           root_en_i = 1'b1;
    logic [3:0]     scan_mode_i = 4'h9;
    logic [4*N-1:0] idle_i = {N{4'h9}};
    logic [N-1:0]   gclk_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int unsigned edge_cnt [N];
    int unsigned delta [N];

    always #5   clk_i = ~clk_i;       // 100 MHz
    always #6.5 root_clk_i = ~root_clk_i;

    hgc_ctrl #(.NUM_UNITS(N)) u_dut (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .hint_we_i    (hint_we_i),
        .hint_wdata_i (hint_wdata_i),
        .hint_q_o     (hint_q_o),
        .status_o     (status_o),
        .root_clk_i   (root_clk_i),
        .root_en_i    (root_en_i),
        .scan_mode_i  (scan_mode_i),
        .idle_i       (idle_i),
        .gclk_o       (gclk_o)
    );

    generate
        for (genvar g = 0; g < N; g++) begin : g_cnt
            initial edge_cnt[g] = 0;
            always @(posedge gclk_o[g]) edge_cnt[g] = edge_cnt[g] + 1;
        end
    endgenerate

    task automatic check_vec(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic write_hint(logic [N-1:0] v);
        @(negedge clk_i);
        hint_we_i = 1'b1;
        hint_wdata_i = v;
        @(negedge clk_i);
        hint_we_i = 1'b0;
    endtask

    task automatic set_idle(int u, logic [3:0] code);
        idle_i[4*u +: 4] = code;
    endtask

    // Let synchronizers settle, then count gated edges and compare status.
    task automatic check_clocks(string req, logic [N-1:0] exp_run);
        logic [N-1:0] running;
        logic [N-1:0] stopped;
        repeat (12) @(negedge clk_i);
        for (int u = 0; u < N; u++) delta[u] = edge_cnt[u];
        repeat (WIN) @(negedge clk_i);
        for (int u = 0; u < N; u++) begin
            delta[u] = edge_cnt[u] - delta[u];
            running[u] = (delta[u] >= RUN_MIN);
            stopped[u] = (delta[u] == 0);
        end
        check_vec(req, "clocks running", running, exp_run);
        check_vec(req, "clocks stopped", stopped, ~exp_run);
        check_vec("R9", {req, " status"}, status_o, exp_run);
    endtask

    task automatic test_reset();
        @(negedge clk_i);
        check_vec("R1", "hint after reset", hint_q_o, '1);
        check_clocks("R1", '1);
    endtask

    task automatic test_write_hold();
        write_hint(5'b10110);
        check_vec("R2", "hint readback", hint_q_o, 5'b10110);
        @(negedge clk_i);
        hint_wdata_i = 5'b00001;
        repeat (3) @(negedge clk_i);
        check_vec("R2", "hint held without write", hint_q_o, 5'b10110);
    endtask

    task automatic test_idle_stop();
        for (int u = 0; u < N; u++) set_idle(u, 4'h6);
        write_hint('0);
        check_clocks("R3", '0);
    endtask

    task automatic test_busy();
        set_idle(2, 4'h9);
        check_clocks("R4", 5'b00100);
    endtask

    task automatic test_invalid_idle();
        set_idle(0, 4'h0);
        set_idle(1, 4'hF);
        set_idle(2, 4'h6);
        set_idle(3, 4'h7);
        set_idle(4, 4'h6);
        check_clocks("R5", 5'b01011);
    endtask

    task automatic test_independent();
        for (int u = 0; u < N; u++) set_idle(u, 4'h6);
        write_hint(5'b01010);
        check_clocks("R8", 5'b01010);
        set_idle(0, 4'h9);
        check_clocks("R8", 5'b01011);
        set_idle(0, 4'h6);
    endtask

    task automatic test_root_off();
        write_hint('1);
        for (int u = 0; u < N; u++) set_idle(u, 4'h9);
        @(negedge clk_i);
        root_en_i = 1'b0;
        check_clocks("R6", '0);
    endtask

    task automatic test_scan();
        @(negedge clk_i);
        scan_mode_i = 4'h6;
        check_clocks("R7", '1);
        @(negedge clk_i);
        scan_mode_i = 4'h2;
        check_clocks("R7", '0);
        @(negedge clk_i);
        scan_mode_i = 4'h9;
        root_en_i = 1'b1;
        for (int u = 0; u < N; u++) set_idle(u, 4'h6);
        write_hint('0);
        @(negedge clk_i);
        scan_mode_i = 4'h6;
        check_clocks("R7", '1);
        @(negedge clk_i);
        scan_mode_i = 4'h9;
        check_clocks("R7", '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #500000;
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk_i);
        rst_i = 1'b0;
        test_reset();
        test_write_hold();
        test_idle_stop();
        test_busy();
        test_invalid_idle();
        test_independent();
        test_root_off();
        test_scan();
        finish_run();
    end
endmodule